// File: doc/BRIEF.md
# Pipelined No-Turnaround Burst SRAM

A synchronous single-port word memory built for a shared data bus that carries read data and write data in the same relative slot. Address, command and byte enables are captured on one clock edge. The command then moves down a two-stage pipeline. For a read, the array is read at the first stage and the word leaves through an output register at the second. For a write, the address and lane mask are held in the same stages, and the write data is taken from the bus at the second stage. Because both directions use the same slot, a read and a write may be issued on consecutive clocks with no idle bus cycle between them.

Addresses come from either a fresh load or a two-bit burst counter that steps inside an aligned group of four words. A mode pin chooses linear or interleaved stepping. Three chip selects qualify each load. An active-low clock enable freezes the whole block. A snooze input turns cycles into bubbles. An output-enable pin gates the data-valid flag without a clock. The bus is modelled as separate `din`, `dq_out` and `dq_oe` signals. The array depth is a parameter, and the storage index is the low `DEPTH_W` bits of the 19-bit address.

Top module: `ntsram_core`

## Requirements
- R1: While the internal reset is active and after it is released, `dq_oe` is low until a read completes. No operation is in flight after reset.
- R2: A read loaded on enabled edge k drives the addressed word on `dq_out` with `dq_oe` high (if `oe_n` is low) after enabled edge k+2.
- R3: A write loaded on enabled edge k stores the `din` value sampled on enabled edge k+2. Reads and writes can alternate on every clock with no idle slot.
- R4: Byte lane i is bits [8i+7:8i] and is enabled by `bw_n[i]` low. A write changes only the enabled lanes. When `gw_n` is low, all four lanes are written regardless of `bw_n`.
- R5: A read issued on the clock after a write to the same word returns the new data in the written lanes and the old data in the others.
- R6: While `cen_n` is high, a clock edge changes no state: no pipeline stage, burst counter, array word or output register changes.
- R7: A load (`adv_ld` low) starts an operation only when `sel0_n`=0, `sel1`=1 and `sel2_n`=0. Any other combination is a deselect: nothing is issued, `dq_oe` stays low in the matching slot, and the burst ends.
- R8: With `adv_ld` high, the next burst address is issued with the command of the last load, and the `addr` and `wr_n` inputs are ignored. After a deselect, or since reset, an advance does nothing.
- R9: With `burst_lin`=1, beat n of a burst uses low address bits (base + n) mod 4. The upper 17 bits stay equal to the loaded address, so the burst wraps within its group of four.
- R10: With `burst_lin`=0, beat n uses low address bits base XOR (n mod 4), with the upper bits held.
- R11: `dq_oe` equals the registered read-slot flag ANDed with `oe_n` low. It follows `oe_n` with no clock and does not disturb the pipeline.
- R12: A cycle with `zz` high issues nothing and leaves the burst state unchanged. Operations already in flight complete.
- R13: Storage uses only the low `DEPTH_W` address bits. Addresses that differ only in the upper bits refer to the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cen_n | input | 1 | Clock enable, low to operate |
| adv_ld | input | 1 | Low: load new address and command; high: advance burst |
| wr_n | input | 1 | Command on load: low = write, high = read |
| gw_n | input | 1 | Low: write all lanes |
| bw_n | input | 4 | Per-lane write enables, active low |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| burst_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| zz | input | 1 | Snooze: no operation accepted |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | 19 | Word address |
| din | input | 4*LANE_W | Write data, sampled two enabled edges after the write is issued |
| dq_out | output | 4*LANE_W | Read data |
| dq_oe | output | 1 | Read data valid and bus driven |

## Verification
The assertions assume that every control input holds a known value on each clock edge after reset, and that a word is read only after it has been written once, because the array has no reset. The bench drives every input just after the falling edge and writes the whole array with global writes before any read, so every read compares against a defined word. Clock enable and snooze are driven freely, including in the middle of bursts. This is safe because both are defined for every pipeline state.

// File: rtl/ntsram_pkg.sv
package ntsram_pkg;
  localparam int ADDR_W  = 19;
  localparam int LANES   = 4;
  localparam int BURST_W = 2;

  typedef struct packed {
    logic              vld;
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [LANES-1:0]  lanes;
  } op_t;
endpackage

// File: rtl/ntsram_issue.sv
module ntsram_issue
  import ntsram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              adv_ld,
  input  logic              wr_n,
  input  logic              zz,
  input  logic              chip_ok,
  input  logic              burst_lin,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lanes,
  output op_t               issue
);
  localparam int UP_W = ADDR_W - BURST_W;

  logic [ADDR_W-1:0]  base_q, base_d;
  logic [BURST_W-1:0] cnt_q, cnt_d, step, low_lin, low_int;
  logic               act_q, act_d, wr_q, wr_d;

  always_comb begin
    step    = cnt_q + BURST_W'(1);
    low_lin = base_q[BURST_W-1:0] + step;
    low_int = base_q[BURST_W-1:0] ^ step;
    base_d  = base_q;
    cnt_d   = cnt_q;
    act_d   = act_q;
    wr_d    = wr_q;
    issue   = '0;
    if (!zz) begin
      if (!adv_ld) begin
        if (chip_ok) begin
          base_d      = addr;
          cnt_d       = '0;
          act_d       = 1'b1;
          wr_d        = !wr_n;
          issue.vld   = 1'b1;
          issue.wr    = !wr_n;
          issue.addr  = addr;
          issue.lanes = lanes;
        end else begin
          act_d = 1'b0;
        end
      end else if (act_q) begin
        cnt_d       = step;
        issue.vld   = 1'b1;
        issue.wr    = wr_q;
        issue.addr  = {base_q[ADDR_W-1:BURST_W], burst_lin ? low_lin : low_int};
        issue.lanes = lanes;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
    end else if (en) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      wr_q   <= wr_d;
    end
  end

  // upper address bits are held during an advance
  assert_adv_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !zz && adv_ld && act_q) |->
      (issue.vld && issue.addr[ADDR_W-1:BURST_W] == base_q[ADDR_W-1:BURST_W]));

  assert_idle_adv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz && adv_ld && !act_q) |-> !issue.vld);

  assert_snooze_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (en && zz) |=> ($stable(base_q) && $stable(cnt_q) && $stable(act_q)));

  logic [UP_W-1:0] unused_up;
  assign unused_up = '0;
endmodule

// File: rtl/ntsram_array.sv
module ntsram_array
  import ntsram_pkg::*;
#(
  parameter int LANE_W  = 8,
  parameter int DEPTH_W = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic                      rd_en,
  input  logic [DEPTH_W-1:0]        rd_addr,
  input  logic                      wr_en,
  input  logic [DEPTH_W-1:0]        wr_addr,
  input  logic [LANES-1:0]          wr_lanes,
  input  logic [LANES*LANE_W-1:0]   wr_data,
  output logic [LANES*LANE_W-1:0]   rd_data
);
  localparam int DEPTH = 1 << DEPTH_W;

  logic fwd_hit;
  assign fwd_hit = wr_en && (wr_addr == rd_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_d, rd_q;

    always_comb begin
      if (fwd_hit && wr_lanes[g]) rd_d = wr_data[g*LANE_W +: LANE_W];
      else                        rd_d = mem[rd_addr];
    end

    always_ff @(posedge clk) begin
      if (en && wr_en && wr_lanes[g]) mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (en && rd_en) rd_q <= rd_d;
    end

    assign rd_data[g*LANE_W +: LANE_W] = rd_q;
  end

  // a read meeting a full-word write in the same edge returns the new word
  assert_fwd_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rd_en && wr_en && wr_addr == rd_addr && wr_lanes == '1) |=>
      (rd_data == $past(wr_data)));
endmodule

// File: rtl/ntsram_outreg.sv
module ntsram_outreg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              slot_rd,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  logic [DATA_W-1:0] dout_q, dout_d;
  logic              slot_q, slot_d;

  always_comb begin
    dout_d = dout_q;
    slot_d = slot_q;
    if (en) begin
      slot_d = slot_rd;
      if (slot_rd) dout_d = rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      slot_q <= 1'b0;
    end else begin
      dout_q <= dout_d;
      slot_q <= slot_d;
    end
  end

  assign dq_out = dout_q;
  assign dq_oe  = slot_q & ~oe_n;

  assert_read_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && slot_rd) |=> (slot_q && dq_out == $past(rd_data)));
endmodule

// File: rtl/ntsram_core.sv
module ntsram_core
  import ntsram_pkg::*;
#(
  parameter int LANE_W  = 8,
  parameter int DEPTH_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cen_n,
  input  logic                    adv_ld,
  input  logic                    wr_n,
  input  logic                    gw_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    sel0_n,
  input  logic                    sel1,
  input  logic                    sel2_n,
  input  logic                    burst_lin,
  input  logic                    zz,
  input  logic                    oe_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);
  localparam int DATA_W = LANES * LANE_W;

  logic rs1_q, rs2_q, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rs2_q, rs1_q} <= 2'b00;
    else        {rs2_q, rs1_q} <= {rs1_q, 1'b1};
  end
  assign rst_sn = rs2_q;

  logic             en, chip_ok;
  logic [LANES-1:0] lanes;
  assign en      = !cen_n;
  assign chip_ok = !sel0_n && sel1 && !sel2_n;
  assign lanes   = gw_n ? ~bw_n : '1;

  op_t issue_op, op1_q, op1_d, op2_q, op2_d;

  ntsram_issue u_issue (
    .clk(clk), .rst_n(rst_sn), .en(en), .adv_ld(adv_ld), .wr_n(wr_n),
    .zz(zz), .chip_ok(chip_ok), .burst_lin(burst_lin), .addr(addr),
    .lanes(lanes), .issue(issue_op)
  );

  always_comb begin
    op1_d = op1_q;
    op2_d = op2_q;
    if (en) begin
      op1_d = issue_op;
      op2_d = op1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      op1_q <= '0;
      op2_q <= '0;
    end else begin
      op1_q <= op1_d;
      op2_q <= op2_d;
    end
  end

  logic [DATA_W-1:0] rd_data;

  ntsram_array #(.LANE_W(LANE_W), .DEPTH_W(DEPTH_W)) u_array (
    .clk(clk), .rst_n(rst_sn), .en(en),
    .rd_en(op1_q.vld && !op1_q.wr), .rd_addr(op1_q.addr[DEPTH_W-1:0]),
    .wr_en(op2_q.vld && op2_q.wr), .wr_addr(op2_q.addr[DEPTH_W-1:0]),
    .wr_lanes(op2_q.lanes), .wr_data(din), .rd_data(rd_data)
  );

  ntsram_outreg #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_sn), .en(en), .slot_rd(op2_q.vld && !op2_q.wr),
    .rd_data(rd_data), .oe_n(oe_n), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  assert_stall_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    cen_n |=> ($stable(op1_q) && $stable(op2_q) && $stable(dq_out)));

  assert_deselect_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    (!cen_n && !zz && !adv_ld && !chip_ok) |=> !op1_q.vld);

  assert_snooze_bubble_R12: assert property (@(posedge clk) disable iff (!rst_sn)
    (!cen_n && zz) |=> !op1_q.vld);
endmodule

// File: tb/sim_ntsram_core.sv
`timescale 1ns/1ps
module sim_ntsram_core;
  localparam int LW = 8;
  localparam int DW = 6;
  localparam int XW = 4 * LW;

  logic clk, rst_n, cen_n, adv_ld, wr_n, gw_n, sel0_n, sel1, sel2_n, burst_lin, zz, oe_n;
  logic [3:0]    bw_n;
  logic [18:0]   addr;
  logic [XW-1:0] din, dq_out;
  logic          dq_oe;

  ntsram_core #(.LANE_W(LW), .DEPTH_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .adv_ld(adv_ld), .wr_n(wr_n),
    .gw_n(gw_n), .bw_n(bw_n), .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
    .burst_lin(burst_lin), .zz(zz), .oe_n(oe_n), .addr(addr), .din(din),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int    n_chk = 0, n_bad = 0;
  string req = "R1";
  bit    done = 0;

  logic [XW-1:0] mm [1<<DW];
  logic m1v, m1w, m2v, m2w, bact, bwr, e_oe;
  logic [18:0] m1a, m2a, bbase;
  logic [3:0]  m1b, m2b;
  logic [1:0]  bcnt;
  logic [XW-1:0] e_dout;

  task automatic chk(input bit ok, input string what, input logic [XW-1:0] act, input logic [XW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // reference model of one enabled edge, written from the requirements
  task automatic model_edge();
    logic [3:0] ln;
    if (cen_n) return;
    if (m2v) begin
      if (m2w) begin
        for (int l = 0; l < 4; l++)
          if (m2b[l]) mm[m2a[DW-1:0]][l*LW +: LW] = din[l*LW +: LW];
      end else e_dout = mm[m2a[DW-1:0]];
    end
    e_oe = m2v && !m2w;
    m2v = m1v; m2w = m1w; m2a = m1a; m2b = m1b;
    m1v = 1'b0;
    ln = gw_n ? ~bw_n : 4'hF;
    if (!zz) begin
      if (!adv_ld) begin
        if (!sel0_n && sel1 && !sel2_n) begin
          bbase = addr; bcnt = 2'd0; bact = 1'b1; bwr = !wr_n;
          m1v = 1'b1; m1w = !wr_n; m1a = addr; m1b = ln;
        end else bact = 1'b0;
      end else if (bact) begin
        bcnt = bcnt + 2'd1;
        m1v = 1'b1; m1w = bwr; m1b = ln;
        m1a = {bbase[18:2], burst_lin ? bbase[1:0] + bcnt : bbase[1:0] ^ bcnt};
      end
    end
  endtask

  task automatic tick();
    string sv;
    din  = $urandom;
    oe_n = 1'($urandom_range(0, 1));
    @(posedge clk);
    if (rst_n) model_edge();
    @(negedge clk);
    chk(dq_oe === (e_oe && !oe_n), "dq_oe", XW'(dq_oe), XW'(e_oe && !oe_n));
    if (e_oe && !oe_n) chk(dq_out === e_dout, "dq_out", dq_out, e_dout);
    oe_n = !oe_n;
    #1;
    sv = req; req = "R11";
    chk(dq_oe === (e_oe && !oe_n), "dq_oe async", XW'(dq_oe), XW'(e_oe && !oe_n));
    req = sv;
  endtask

  task automatic ld(input logic w, input logic [18:0] a, input logic [3:0] bn, input logic g);
    adv_ld = 1'b0; wr_n = !w; addr = a; bw_n = bn; gw_n = g;
    tick();
  endtask

  task automatic av(input logic [3:0] bn, input logic g);
    adv_ld = 1'b1; wr_n = 1'($urandom_range(0, 1)); addr = 19'($urandom); bw_n = bn; gw_n = g;
    tick();
  endtask

  task automatic rnd_op();
    int k;
    k = $urandom_range(0, 3);
    if (k == 0)      ld(1'b1, 19'($urandom), 4'($urandom), 1'($urandom_range(0, 1)));
    else if (k == 1) ld(1'b0, 19'($urandom), 4'hF, 1'b1);
    else             av(4'($urandom), 1'($urandom_range(0, 1)));
  endtask

  initial begin
    #1600000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired in %s", req);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cen_n = 1'b0; adv_ld = 1'b1; wr_n = 1'b1; gw_n = 1'b1; bw_n = 4'hF;
    sel0_n = 1'b0; sel1 = 1'b1; sel2_n = 1'b0; burst_lin = 1'b1; zz = 1'b0; oe_n = 1'b0;
    addr = '0; din = '0;
    m1v = 0; m1w = 0; m2v = 0; m2w = 0; bact = 0; bwr = 0; e_oe = 0;
    m1a = '0; m2a = '0; m1b = '0; m2b = '0; bbase = '0; bcnt = '0; e_dout = '0;

    // R1: reset state
    req = "R1";
    repeat (3) begin
      @(negedge clk);
      chk(dq_oe === 1'b0, "dq_oe in reset", XW'(dq_oe), '0);
    end
    rst_n = 1'b1;
    repeat (4) tick();

    // R3/R13: fill every word with global writes, upper bits random
    req = "R3";
    for (int i = 0; i < (1 << DW); i++)
      ld(1'b1, {13'($urandom), 6'(i)}, 4'hF, 1'b0);
    req = "R13";
    for (int i = 0; i < (1 << DW); i++)
      ld(1'b0, {13'($urandom), 6'(i)}, 4'hF, 1'b1);
    // R3: write and read alternating on every clock, different words
    req = "R3";
    for (int i = 0; i < (1 << DW); i++) begin
      ld(1'b1, 19'(i), 4'($urandom), 1'b0);
      ld(1'b0, 19'((i + 17) % (1 << DW)), 4'hF, 1'b1);
    end
    // R2: plain reads across the array
    req = "R2";
    for (int i = 0; i < (1 << DW); i++) ld(1'b0, 19'(i), 4'hF, 1'b1);

    // R4/R5: every lane mask, read of the same word on the next clock
    for (int i = 0; i < (1 << DW); i++) begin
      req = "R4";
      ld(1'b1, 19'(i), 4'(i), (i < 48));
      req = "R5";
      ld(1'b0, 19'(i), 4'hF, 1'b1);
    end

    // R9/R10/R8: bursts from every offset, six beats to show wrap
    for (int lm = 0; lm < 2; lm++) begin
      burst_lin = 1'(lm);
      req = lm ? "R9" : "R10";
      for (int off = 0; off < 4; off++) begin
        logic [18:0] b;
        b = {15'($urandom), 2'($urandom), 2'(off)};
        ld(1'b1, b, 4'($urandom), 1'($urandom_range(0, 1)));
        for (int n = 0; n < 5; n++) av(4'($urandom), 1'($urandom_range(0, 1)));
        ld(1'b0, b, 4'hF, 1'b1);
        for (int n = 0; n < 5; n++) av(4'hF, 1'b1);
      end
    end
    req = "R8";
    repeat (3) tick();

    // R7: every chip-select combination, read and write loads, then advances
    for (int s = 0; s < 8; s++) begin
      for (int w = 0; w < 2; w++) begin
        req = "R7";
        sel0_n = s[0]; sel1 = s[1]; sel2_n = s[2];
        ld(1'(w), 19'($urandom), 4'h0, 1'b0);
        sel0_n = 1'b0; sel1 = 1'b1; sel2_n = 1'b0;
        req = "R8";
        av(4'h0, 1'b0);
        av(4'h0, 1'b0);
        ld(1'b0, 19'($urandom), 4'hF, 1'b1);
        ld(1'b0, 19'($urandom), 4'hF, 1'b1);
      end
    end

    // R6: clock enable stalls mixed into random traffic
    req = "R6";
    for (int n = 0; n < 300; n++) begin
      cen_n = ($urandom_range(0, 2) == 0);
      burst_lin = 1'($urandom_range(0, 1));
      rnd_op();
    end
    cen_n = 1'b0;

    // R12: snooze cycles mixed into random traffic
    req = "R12";
    for (int n = 0; n < 300; n++) begin
      zz = ($urandom_range(0, 2) == 0);
      cen_n = ($urandom_range(0, 5) == 0);
      rnd_op();
    end
    zz = 1'b0; cen_n = 1'b0;

    req = "R2";
    adv_ld = 1'b1;
    repeat (4) tick();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule